// File: doc/BRIEF.md
# Three-wire serial EEPROM slave (2 Kbit, selectable organisation)

This block behaves as a small serial EEPROM behind a three-wire select/clock/data interface. A host raises the select line, clocks in a start bit, a two-bit opcode and an address on rising edges of the serial clock. It then either clocks data out of the block or clocks write data in. The 2048-bit store is held in on-chip registers. A level on the organisation pin decides whether the store is seen as 256 bytes or as 128 sixteen-bit words.

Reads keep going for as long as select stays high. The location pointer steps forward after every location and wraps to zero past the top. Programming instructions start a self-timed busy period when select is dropped. The busy period is counted in cycles of the free-running system clock. When select is raised again, the serial output shows the busy/ready state. The serial pins are sampled by that system clock, so the serial clock must be much slower than it.

Top module: `mw_eeprom`

## Requirements
- R1: With `org` high the store is 128 words of 16 bits and takes 7 address bits. With `org` low it is 256 bytes of 8 bits and takes 8 address bits. Word `a` consists of byte `2a` (upper half) and byte `2a+1` (lower half).
- R2: Every instruction starts with the first 1 sampled on `sdi` at a rising `sclk` edge while `sel` is high; zeros before it are skipped. Two opcode bits follow (10 read, 01 write, 11 erase, 00 extended), then the address, all sent MSB first. For the extended opcode, the two top address bits select the action: 11 write-enable, 00 write-disable, 10 erase-all, 01 write-all.
- R3: After the last address bit of a read, `sdo` presents the addressed location MSB first, with `sdo_oe` high. Each further rising `sclk` edge advances one bit.
- R4: After the last bit of a location, a read carries on with the next address. Past the highest address it wraps to address 0, in both organisations.
- R5: A write takes one full byte or word, MSB first, and replaces the old contents with no prior erase. Programming begins when `sel` falls after the last data bit.
- R6: Erase sets one location to all ones. Erase-all sets every location to all ones. After reset, every location reads as all ones.
- R7: Write-all stores the supplied byte or word in every location.
- R8: Write, erase, erase-all and write-all have no effect and start no busy period unless write-enable is the most recent enable instruction. After reset, writes are disabled.
- R9: A programming instruction keeps the block busy for `PROG_CYCLES` system clocks. While select is high, `sdo` is driven low when busy and high when ready. Start bits are ignored while busy.
- R10: `sdo_oe` is low on the clock after any cycle in which `sel` is low.
- R11: Dropping `sel` before a programming instruction is complete discards it, and no location changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| sdi | input | 1 | Serial data in |
| org | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| sdo | output | 1 | Serial data out, or busy/ready status |
| sdo_oe | output | 1 | High when `sdo` is driven; low stands for high impedance |

## Verification
The assertions assume that `org` changes only while `sel` is low. They also assume that each `sclk` level and each `sdi` value is held for several system clocks, so that every serial edge is seen exactly once. The bench holds every serial phase for four system clocks. It changes `sdi` only with `sclk` low and switches `org` only between instructions. It sends status checks and instructions sent during a busy period only while the block is idle or busy, never in the middle of a read stream.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int ADDR_W = 8;
    localparam int N_BYTES = 1 << ADDR_W;
    localparam int CMD_W = 2 + ADDR_W;

    typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_HOLD} mw_state_e;
    typedef enum logic [2:0] {P_NONE, P_WRITE, P_ERASE, P_ERAL, P_WRAL} mw_prog_e;

    typedef struct packed {
        logic [1:0]        op;
        logic [1:0]        ext;
        logic [ADDR_W-1:0] addr;
    } mw_cmd_t;

    function automatic int addr_len(input logic org);
        return org ? ADDR_W - 1 : ADDR_W;
    endfunction

    function automatic int data_len(input logic org);
        return org ? WORD_W : BYTE_W;
    endfunction

    function automatic mw_cmd_t split_cmd(input logic [CMD_W-1:0] f, input logic org);
        mw_cmd_t c;
        if (org) begin
            c.op   = f[CMD_W-2:CMD_W-3];
            c.addr = {1'b0, f[ADDR_W-2:0]};
            c.ext  = f[ADDR_W-2:ADDR_W-3];
        end else begin
            c.op   = f[CMD_W-1:CMD_W-2];
            c.addr = f[ADDR_W-1:0];
            c.ext  = f[ADDR_W-1:ADDR_W-2];
        end
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p, input logic org);
        logic [ADDR_W-1:0] n;
        n = p + 1'b1;
        if (org) n[ADDR_W-1] = 1'b0;
        return n;
    endfunction
endpackage

// File: rtl/mw_sync.sv
module mw_sync (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    output logic sel_q,
    output logic sdi_q,
    output logic rise
);
    logic sclk_q, sclk_qq;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b0;
            sdi_q   <= 1'b0;
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
        end else begin
            sel_q   <= sel;
            sdi_q   <= sdi;
            sclk_q  <= sclk;
            sclk_qq <= sclk_q;
        end
    end

    assign rise = sclk_q & ~sclk_qq;
endmodule

// File: rtl/mw_ptimer.sv
module mw_ptimer #(
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)             left_q <= '0;
        else if (start)      left_q <= CNT_W'(PROG_CYCLES);
        else if (left_q != 0) left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != 0);
endmodule

// File: rtl/mw_store.sv
module mw_store
    import mw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  mw_prog_e          op,
    input  logic              org,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [BYTE_W-1:0] mem_q [N_BYTES];
    logic [ADDR_W-1:0] w_hi, w_lo, r_hi, r_lo;

    assign w_hi = {waddr[ADDR_W-2:0], 1'b0};
    assign w_lo = {waddr[ADDR_W-2:0], 1'b1};
    assign r_hi = {raddr[ADDR_W-2:0], 1'b0};
    assign r_lo = {raddr[ADDR_W-2:0], 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_BYTES; i++) mem_q[i] <= '1;
        end else if (we) begin
            case (op)
                P_WRITE: begin
                    if (org) begin
                        mem_q[w_hi] <= wdata[WORD_W-1:BYTE_W];
                        mem_q[w_lo] <= wdata[BYTE_W-1:0];
                    end else begin
                        mem_q[waddr] <= wdata[BYTE_W-1:0];
                    end
                end
                P_ERASE: begin
                    if (org) begin
                        mem_q[w_hi] <= '1;
                        mem_q[w_lo] <= '1;
                    end else begin
                        mem_q[waddr] <= '1;
                    end
                end
                P_ERAL: for (int i = 0; i < N_BYTES; i++) mem_q[i] <= '1;
                P_WRAL: for (int i = 0; i < N_BYTES; i++)
                    mem_q[i] <= (org && !i[0]) ? wdata[WORD_W-1:BYTE_W] : wdata[BYTE_W-1:0];
                default: ;
            endcase
        end
    end

    assign rdata = org ? {mem_q[r_hi], mem_q[r_lo]} : {{BYTE_W{1'b0}}, mem_q[raddr]};
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    input  logic org,
    output logic sdo,
    output logic sdo_oe
);
    logic              sel_q, sdi_q, rise, busy;
    mw_state_e         state_q;
    mw_prog_e          pend_q, lop_q;
    logic [CMD_W-2:0]  sh_q;
    logic [WORD_W-1:0] dsh_q, rdata;
    logic [ADDR_W-1:0] ptr_q;
    logic [4:0]        cnt_q;
    logic              wen_q, stat_q, launch_q;
    mw_cmd_t           cmd;
    int                alen, dlen, bit_pos;

    mw_sync u_sync (.clk(clk), .rst(rst), .sel(sel), .sclk(sclk), .sdi(sdi),
                    .sel_q(sel_q), .sdi_q(sdi_q), .rise(rise));

    mw_ptimer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(launch_q), .busy(busy));

    mw_store u_store (.clk(clk), .rst(rst), .we(launch_q), .op(lop_q), .org(org),
                      .waddr(ptr_q), .wdata(dsh_q), .raddr(ptr_q), .rdata(rdata));

    always_comb begin
        alen    = addr_len(org);
        dlen    = data_len(org);
        cmd     = split_cmd({sh_q, sdi_q}, org);
        bit_pos = dlen - 1 - int'(cnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            pend_q   <= P_NONE;
            lop_q    <= P_NONE;
            sh_q     <= '0;
            dsh_q    <= '0;
            ptr_q    <= '0;
            cnt_q    <= '0;
            wen_q    <= 1'b0;
            stat_q   <= 1'b0;
            launch_q <= 1'b0;
        end else begin
            launch_q <= 1'b0;
            if (!sel_q) begin
                if (state_q == S_HOLD && pend_q != P_NONE && wen_q) begin
                    launch_q <= 1'b1;
                    lop_q    <= pend_q;
                    stat_q   <= 1'b1;
                end
                state_q <= S_IDLE;
                pend_q  <= P_NONE;
            end else if (rise) begin
                case (state_q)
                    S_IDLE: if (sdi_q && !busy) begin
                        state_q <= S_CMD;
                        cnt_q   <= '0;
                        stat_q  <= 1'b0;
                    end
                    S_CMD: begin
                        sh_q  <= {sh_q[CMD_W-3:0], sdi_q};
                        cnt_q <= cnt_q + 1'b1;
                        if (int'(cnt_q) == alen + 1) begin
                            ptr_q <= cmd.addr;
                            cnt_q <= '0;
                            case (cmd.op)
                                2'b10: state_q <= S_READ;
                                2'b01: begin state_q <= S_DATA; pend_q <= P_WRITE; end
                                2'b11: begin state_q <= S_HOLD; pend_q <= P_ERASE; end
                                default: begin
                                    state_q <= S_HOLD;
                                    case (cmd.ext)
                                        2'b11: wen_q <= 1'b1;
                                        2'b00: wen_q <= 1'b0;
                                        2'b10: pend_q <= P_ERAL;
                                        default: begin state_q <= S_DATA; pend_q <= P_WRAL; end
                                    endcase
                                end
                            endcase
                        end
                    end
                    S_DATA: begin
                        dsh_q <= {dsh_q[WORD_W-2:0], sdi_q};
                        cnt_q <= cnt_q + 1'b1;
                        if (int'(cnt_q) == dlen - 1) state_q <= S_HOLD;
                    end
                    S_READ: begin
                        if (int'(cnt_q) == dlen - 1) begin
                            cnt_q <= '0;
                            ptr_q <= step_ptr(ptr_q, org);
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        sdo_oe = 1'b0;
        sdo    = 1'b0;
        if (sel_q && state_q == S_READ) begin
            sdo_oe = 1'b1;
            sdo    = rdata[bit_pos[3:0]];
        end else if (sel_q && state_q == S_IDLE && stat_q) begin
            sdo_oe = 1'b1;
            sdo    = ~busy;
        end
    end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
    parameter int PROG_CYCLES = 5000
) (
    input logic       clk,
    input logic       rst,
    input logic       sel,
    input logic       org,
    input logic       sdo,
    input logic       sdo_oe,
    input logic       busy,
    input logic       wen_q,
    input logic       reading,
    input logic [7:0] ptr_q
);
    int unsigned busy_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_len <= 0;
        else              busy_len <= busy_len + 1;
    end

    assert_oe_off_R10: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !sdo_oe);

    assert_launch_enabled_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wen_q));

    assert_busy_len_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_len == PROG_CYCLES);

    assert_busy_shows_low_R9: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && busy) |-> !sdo);

    assert_word_ptr_R4: assert property (@(posedge clk) disable iff (rst)
        (org && reading) |-> !ptr_q[7]);
endmodule

bind mw_eeprom mw_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .sel(sel), .org(org), .sdo(sdo), .sdo_oe(sdo_oe),
    .busy(busy), .wen_q(wen_q), .reading(state_q == mw_pkg::S_READ), .ptr_q(ptr_q));

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;
    localparam int PROG = 200;

    logic clk = 1'b0, rst = 1'b1;
    logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0, org = 1'b1;
    logic sdo, sdo_oe;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mdl [256];
    bit mwen = 1'b0;
    bit exp_q [$];
    string req_q [$];
    event smp_ev;

    always #2.5 clk = ~clk;

    mw_eeprom #(.PROG_CYCLES(PROG)) u_mw_eeprom (
        .clk(clk), .rst(rst), .sel(sel), .sclk(sclk), .sdi(sdi), .org(org),
        .sdo(sdo), .sdo_oe(sdo_oe));

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected read bits and compares them against the pins
    initial forever begin
        @(smp_ev);
        if (exp_q.size() != 0) begin
            automatic bit e = exp_q.pop_front();
            automatic string r = req_q.pop_front();
            chk(sdo_oe && sdo == e, r, {sdo_oe, sdo}, {1'b1, e});
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic clk_n(int n); repeat (n) @(negedge clk); endtask

    task automatic sbit(bit b);
        sdi = b; sclk = 1'b0; clk_n(4);
        sclk = 1'b1; clk_n(4);
    endtask

    function automatic int alen(); return org ? 7 : 8; endfunction
    function automatic int dlen(); return org ? 16 : 8; endfunction
    function automatic int depth(); return org ? 128 : 256; endfunction

    function automatic int mword(int a);
        return org ? {mdl[2*a], mdl[2*a+1]} : int'(mdl[a]);
    endfunction

    function automatic void mset(int a, int d);
        if (org) begin mdl[2*a] = d[15:8]; mdl[2*a+1] = d[7:0]; end
        else mdl[a] = d[7:0];
    endfunction

    task automatic begin_cmd(bit [1:0] op, int addr, int zeros = 0);
        sel = 1'b1; clk_n(2);
        for (int i = 0; i < zeros; i++) sbit(1'b0);
        sbit(1'b1); sbit(op[1]); sbit(op[0]);
        for (int i = alen() - 1; i >= 0; i--) sbit(addr[i]);
    endtask

    task automatic end_cmd();
        sclk = 1'b0; sdi = 1'b0; sel = 1'b0; clk_n(4);
    endtask

    task automatic send_data(int d, int nbits);
        for (int i = nbits - 1; i >= 0; i--) sbit(d[i]);
    endtask

    task automatic check_status(bit expect_busy, string req);
        sel = 1'b1; clk_n(3);
        if (expect_busy) begin
            chk(sdo_oe && !sdo, req, {sdo_oe, sdo}, 2'b10);
            clk_n(PROG + 10);
            chk(sdo_oe && sdo, req, {sdo_oe, sdo}, 2'b11);
        end else begin
            chk(!sdo_oe, req, sdo_oe, 0);
        end
        sel = 1'b0; clk_n(4);
    endtask

    task automatic do_read(int addr, int nwords, string req, int zeros = 0);
        begin_cmd(2'b10, addr, zeros);
        for (int w = 0; w < nwords; w++) begin
            automatic int v = mword((addr + w) % depth());
            for (int b = dlen() - 1; b >= 0; b--) begin
                exp_q.push_back(v[b]);
                req_q.push_back(req);
                sclk = 1'b0; clk_n(4);
                -> smp_ev;
                clk_n(1);
                sclk = 1'b1; clk_n(3);
            end
        end
        end_cmd();
    endtask

    task automatic do_write(int addr, int d, string req);
        begin_cmd(2'b01, addr);
        send_data(d, dlen());
        end_cmd();
        if (mwen) mset(addr, d);
        check_status(mwen, req);
    endtask

    task automatic do_ext(bit [1:0] ext);
        begin_cmd(2'b00, ext << (alen() - 2));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
        clk_n(5);
        chk(!sdo_oe, "R10 reset", sdo_oe, 0);
        rst = 1'b0; clk_n(4);

        // word mode: writes before enable are ignored (R8), erased state (R6)
        org = 1'b1;
        do_write(5, 16'h1234, "R8 disabled write");
        do_read(5, 1, "R8 R6 reset ones");

        do_ext(2'b11); end_cmd(); mwen = 1'b1;
        do_write(5, 16'hA5C3, "R5 R9 word write");
        do_write(127, 16'h0F0F, "R5 R9 top word");
        // R4 wrap in word mode, R3 bit order, R2 leading zeros
        do_read(126, 3, "R3 R4 word stream", 3);
        do_read(5, 1, "R5 word readback");

        // byte mode: same store seen as bytes (R1)
        org = 1'b0;
        do_read(10, 2, "R1 byte view");
        do_write(255, 8'h3C, "R5 byte write");
        do_read(255, 2, "R4 byte wrap");

        // single erase (R6)
        begin_cmd(2'b11, 10); end_cmd(); mdl[10] = 8'hFF;
        check_status(1'b1, "R6 erase busy");
        do_read(10, 2, "R6 erase byte");

        // R11: abort in mid data
        begin_cmd(2'b01, 20); send_data(4'hA, 4); end_cmd();
        check_status(1'b0, "R11 abort no busy");
        do_read(20, 1, "R11 abort no change");

        // R9: start bits ignored during busy
        do_write(30, 8'h81, "R9 prep");
        begin_cmd(2'b01, 31); send_data(8'h42, 8); end_cmd(); mset(31, 8'h42);
        sel = 1'b1; clk_n(3);
        sbit(1'b1); sbit(1'b1); sbit(1'b0);
        for (int i = 0; i < 8; i++) sbit(1'b0);
        sclk = 1'b0; clk_n(4);
        chk(sdo_oe && !sdo, "R9 start ignored while busy", {sdo_oe, sdo}, 2'b10);
        clk_n(PROG);
        chk(sdo_oe && sdo, "R9 ready after busy", {sdo_oe, sdo}, 2'b11);
        sel = 1'b0; clk_n(4);
        do_read(30, 2, "R9 data after busy");

        // R8: disable, then write ignored
        do_ext(2'b00); end_cmd(); mwen = 1'b0;
        do_write(0, 8'h00, "R8 write after disable");
        do_read(0, 1, "R8 disabled keeps data");
        do_ext(2'b11); end_cmd(); mwen = 1'b1;

        // R7 write-all in byte mode
        do_ext(2'b01); send_data(8'h5A, 8); end_cmd();
        for (int i = 0; i < 256; i++) mdl[i] = 8'h5A;
        check_status(1'b1, "R7 write-all busy");
        do_read(0, 1, "R7 byte 0");
        do_read(200, 1, "R7 byte 200");

        // R7 write-all in word mode, then R6 erase-all
        org = 1'b1;
        do_ext(2'b01); send_data(16'hBE21, 16); end_cmd();
        for (int i = 0; i < 128; i++) mset(i, 16'hBE21);
        check_status(1'b1, "R7 word write-all busy");
        do_read(64, 1, "R7 word write-all");
        do_ext(2'b10); end_cmd();
        for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
        check_status(1'b1, "R6 erase-all busy");
        do_read(77, 1, "R6 erase-all");

        sel = 1'b0; clk_n(2);
        chk(!sdo_oe, "R10 deselected", sdo_oe, 0);
        summary();
    end
endmodule